// File: doc/BRIEF.md
# Serial Byte Transmitter with Queue

This block turns queued bytes into an asynchronous serial stream. A producer writes bytes into a 64-entry queue through a single-cycle write strobe. Whenever the queue holds data and the line is free, the transmitter takes the oldest byte and sends a frame on `txd`: a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop interval. The line rests high between frames.

All frame timing comes from an internal tick. The tick fires once every `divisor + 2` clock cycles, and every bit lasts 16 ticks. The frame format inputs are captured when a byte leaves the queue. Changing them therefore affects only frames that have not yet started. A one-cycle interrupt pulse marks the moment the queue runs dry. A separate level output reports that nothing is left to send, which covers both the queue and the frame in flight.

Top module: `sertx_core`

## Requirements
- R1: The queue holds 64 bytes. `fifo_full` is high while 64 bytes are held, and a write strobe seen while `fifo_full` is high is dropped, so that byte is never transmitted.
- R2: The tick period is `divisor + 2` clock cycles, and each bit on `txd` lasts exactly 16 ticks.
- R3: `txd` is high when idle. A frame starts with one low bit, and the data follows least significant bit first.
- R4: `fmt_len` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected width are not sent.
- R5: With `fmt_par_en` set, one parity bit follows the data. When `fmt_par_odd` is 0, that bit makes the count of ones across data and parity even. When it is 1, the count is odd. With `fmt_par_en` clear, no parity bit is sent.
- R6: The stop interval is high for 16 ticks when `fmt_stop_long` is 0. When it is 1, the interval is 24 ticks for 5-bit data and 32 ticks for 6- to 8-bit data. A queued byte starts its frame at the tick that ends the previous stop interval, with no gap.
- R7: `empty_irq` is high for exactly one cycle. That cycle follows a read that leaves the queue empty.
- R8: `tx_idle` is high only when the queue is empty and no frame is in progress. The stop interval counts as part of the frame.
- R9: While `rst` is high and after it falls, `txd` is high, `tx_idle` is high, and `fifo_full` and `empty_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: stores `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds 64 bytes |
| divisor | input | 16 | Tick period is divisor + 2 clocks |
| fmt_len | input | 2 | Data width code (0..3 → 5..8 bits) |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 even |
| fmt_stop_long | input | 1 | Long stop interval (1.5 or 2 bits) |
| txd | output | 1 | Serial output, idles high |
| empty_irq | output | 1 | One-cycle pulse when the queue empties |
| tx_idle | output | 1 | Queue empty and no frame in progress |

## Verification
The assertions check, on every cycle, the structural invariants:
- the queue level never exceeds its depth, and a dropped write leaves the level unchanged;
- ticks are never adjacent, and `txd` changes only on a tick;
- the line is high whenever `tx_idle` is set;
- the interrupt is a single-cycle pulse that appears only with an empty queue.

Some properties can only be shown by the bench's scenarios, which sample every bit at its midpoint and compare it against an independent model of the frame:
- bit order, width masking and parity polarity;
- the exact 24- and 32-tick stop intervals, measured as the spacing between back-to-back frame starts;
- the actual tick period at a non-zero divisor;
- the loss of a byte written into a full queue.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned FRAME_W = 10;   // start + 8 data + parity
    localparam int unsigned STOP_W  = 6;    // holds up to 32 ticks

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_STOP = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;        // bit 0 goes out first
        logic [3:0]         nbits;       // start + data + parity
        logic [STOP_W-1:0]  stop_ticks;  // stop interval length in ticks
    } frame_t;

    // Lay out one character: start bit, data LSB first, optional parity.
    function automatic frame_t build_frame(input logic [7:0] data,
                                           input logic [1:0] len,
                                           input logic       par_en,
                                           input logic       par_odd,
                                           input logic       stop_long);
        frame_t     f;
        int         nd;
        logic [7:0] kept;
        nd        = 5 + int'(len);
        kept      = data & (8'hFF >> (2'd3 - len));
        f.bits    = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < nd) f.bits[i+1] = data[i];
        end
        if (par_en) f.bits[nd+1] = (^kept) ^ par_odd;
        f.nbits = 4'(1 + nd + (par_en ? 1 : 0));
        if (!stop_long)        f.stop_ticks = 6'd16;
        else if (len == 2'd0)  f.stop_ticks = 6'd24;
        else                   f.stop_ticks = 6'd32;
        return f;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LVL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [LVL_W-1:0]  level,
    output logic              drained
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  count;
    logic              push_ok, pop_ok;

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            drained <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            drained <= pop_ok && !push_ok && (count == LVL_W'(1));
        end
    end
endmodule

// File: rtl/sertx_tick.sv
module sertx_tick #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W:0] cnt;
    logic [DIV_W:0] limit;

    assign limit = {1'b0, divisor} + 1'b1;
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       q_empty,
    input  logic [7:0] q_head,
    input  logic [1:0] fmt_len,
    input  logic       fmt_par_en,
    input  logic       fmt_par_odd,
    input  logic       fmt_stop_long,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    tx_state_e         state;
    frame_t            cur;
    logic [3:0]        sub;      // tick within the current bit
    logic [3:0]        idx;      // bit index within the frame
    logic [STOP_W-1:0] stop_cnt;
    logic              stop_end;

    assign stop_end = (state == ST_STOP) && (stop_cnt == cur.stop_ticks - 1'b1);
    assign pop      = tick && !q_empty && ((state == ST_IDLE) || stop_end);
    assign txd      = (state == ST_BITS) ? cur.bits[0] : 1'b1;
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '{bits: '1, nbits: '0, stop_ticks: '0};
            sub      <= '0;
            idx      <= '0;
            stop_cnt <= '0;
        end else if (pop) begin
            cur      <= build_frame(q_head, fmt_len, fmt_par_en, fmt_par_odd, fmt_stop_long);
            state    <= ST_BITS;
            sub      <= '0;
            idx      <= '0;
        end else if (tick) begin
            case (state)
                ST_BITS: begin
                    sub <= sub + 1'b1;
                    if (sub == 4'd15) begin
                        cur.bits <= {1'b1, cur.bits[FRAME_W-1:1]};
                        if (idx == cur.nbits - 1'b1) begin
                            state    <= ST_STOP;
                            stop_cnt <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (stop_end) state    <= ST_IDLE;
                    else          stop_cnt <= stop_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DIV_W = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             fifo_full,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       fmt_len,
    input  logic             fmt_par_en,
    input  logic             fmt_par_odd,
    input  logic             fmt_stop_long,
    output logic             txd,
    output logic             empty_irq,
    output logic             tx_idle
);
    logic             tick;
    logic             pop;
    logic             q_empty;
    logic             busy;
    logic [7:0]       q_head;
    logic [LVL_W-1:0] fifo_level;

    sertx_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (fifo_full),
        .level     (fifo_level),
        .drained   (empty_irq)
    );

    sertx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (tick)
    );

    sertx_shift u_shift (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .q_empty       (q_empty),
        .q_head        (q_head),
        .fmt_len       (fmt_len),
        .fmt_par_en    (fmt_par_en),
        .fmt_par_odd   (fmt_par_odd),
        .fmt_stop_long (fmt_stop_long),
        .pop           (pop),
        .txd           (txd),
        .busy          (busy)
    );

    assign tx_idle = q_empty && !busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             pop,
    input logic             wr_en,
    input logic             fifo_full,
    input logic             txd,
    input logic             tx_idle,
    input logic             empty_irq,
    input logic [LVL_W-1:0] fifo_level
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(DEPTH));

    assert_full_drop_R1: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && wr_en && !pop) |=> (fifo_level == $past(fifo_level)));

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_txd_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd));

    assert_idle_line_R3: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        empty_irq |=> !empty_irq);

    assert_irq_empty_R7: assert property (@(posedge clk) disable iff (rst)
        empty_irq |-> (fifo_level == '0));

    assert_idle_empty_R8: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> (fifo_level == '0));
endmodule

bind sertx_core sertx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .pop        (pop),
    .wr_en      (wr_en),
    .fifo_full  (fifo_full),
    .txd        (txd),
    .tx_idle    (tx_idle),
    .empty_irq  (empty_irq),
    .fifo_level (fifo_level)
);

// File: tb/sertx_core_tb.sv
module sertx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        fifo_full;
    logic [15:0] divisor = '0;
    logic [1:0]  fmt_len = 2'd3;
    logic        fmt_par_en = 1'b0;
    logic        fmt_par_odd = 1'b0;
    logic        fmt_stop_long = 1'b0;
    logic        txd;
    logic        empty_irq;
    logic        tx_idle;

    sertx_core u_dut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .fifo_full     (fifo_full),
        .divisor       (divisor),
        .fmt_len       (fmt_len),
        .fmt_par_en    (fmt_par_en),
        .fmt_par_odd   (fmt_par_odd),
        .fmt_stop_long (fmt_stop_long),
        .txd           (txd),
        .empty_irq     (empty_irq),
        .tx_idle       (tx_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [7:0] d;
        int         nd;
        bit         pen;
        bit         odd;
        bit         lng;
        int         T;
    } item_t;

    item_t q[$];
    int    starts[$];
    int    cyc = 0;
    int    irq_cnt = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_busy = 1'b0;
    bit    done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && empty_irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int stop_ticks(input item_t it);
        if (!it.lng)     return 16;
        if (it.nd == 5)  return 24;
        return 32;
    endfunction

    function automatic int frame_clocks(input item_t it);
        return ((1 + it.nd + (it.pen ? 1 : 0)) * 16 + stop_ticks(it)) * it.T;
    endfunction

    // Monitor: pops the expected frame at each start edge and samples mid-bit.
    task automatic run_frame();
        item_t      it;
        int         pos, tgt, nb, T;
        logic [7:0] got, mask;
        logic       pexp;
        starts.push_back(cyc);
        if (q.size() == 0) begin
            check(1'b0, "R3", "unexpected frame", 1, 0);
            while (!txd) @(negedge clk);
            return;
        end
        it   = q.pop_front();
        T    = it.T;
        nb   = 1 + it.nd + (it.pen ? 1 : 0);
        mask = 8'hFF >> (8 - it.nd);
        got  = '0;
        pos  = 0;
        for (int k = 0; k <= nb; k++) begin
            tgt = k * 16 * T + 8 * T;
            repeat (tgt - pos) @(negedge clk);
            pos = tgt;
            if (k == 0)            check(txd == 1'b0, "R3", "start bit", txd, 0);
            else if (k <= it.nd)   got[k-1] = txd;
            else if (k < nb) begin
                pexp = (^(it.d & mask)) ^ it.odd;
                check(txd == pexp, "R5", "parity bit", txd, pexp);
            end else               check(txd == 1'b1, "R6", "stop mid", txd, 1);
        end
        check(got == (it.d & mask), "R4", "data bits LSB first (R3)", got, it.d & mask);
        tgt = frame_clocks(it) - 1;
        repeat (tgt - pos) @(negedge clk);
        check(txd == 1'b1, "R6", "stop last cycle", txd, 1);
        check(tx_idle == 1'b0, "R8", "idle during stop", tx_idle, 0);
        if (q.size() == 0) begin
            @(negedge clk);
            check(tx_idle == 1'b1, "R8", "idle after last stop", tx_idle, 1);
            check(txd == 1'b1, "R3", "line idles high", txd, 1);
        end
    endtask

    initial begin
        bit prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst) prev = 1'b1;
            else if (prev && !txd) begin
                mon_busy = 1'b1;
                run_frame();
                mon_busy = 1'b0;
                prev = 1'b1;
            end else prev = txd;
        end
    end

    // Driver: one write per call, aligned to a negative edge.
    task automatic push(input logic [7:0] d, input bit expect_sent);
        item_t it;
        it.d = d; it.nd = 5 + int'(fmt_len); it.pen = fmt_par_en;
        it.odd = fmt_par_odd; it.lng = fmt_stop_long; it.T = int'(divisor) + 2;
        wr_en   = 1'b1;
        wr_data = d;
        if (expect_sent) q.push_back(it);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        while (!mon_busy) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() != 0 || mon_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Two back-to-back frames; the start spacing shows stop length and tick rate.
    task automatic run_pair(input logic [7:0] d1, input logic [7:0] d2, input string req);
        int    n0, i0, exp_gap;
        item_t it;
        n0 = starts.size();
        i0 = irq_cnt;
        push(d1, 1'b1);
        it = q[0];
        wait_start();
        push(d2, 1'b1);
        drain();
        check(starts.size() == n0 + 2, req, "frame count", starts.size() - n0, 2);
        if (starts.size() == n0 + 2) begin
            exp_gap = frame_clocks(it);
            check(starts[n0+1] - starts[n0] == exp_gap, req, "start-to-start clocks",
                  starts[n0+1] - starts[n0], exp_gap);
        end
        check(irq_cnt == i0 + 2, "R7", "empty pulses", irq_cnt - i0, 2);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        int i0;
        // R9: reset state
        repeat (4) @(negedge clk);
        check(txd == 1'b1, "R9", "txd in reset", txd, 1);
        check(tx_idle == 1'b1, "R9", "tx_idle in reset", tx_idle, 1);
        check(fifo_full == 1'b0, "R9", "fifo_full in reset", fifo_full, 0);
        check(empty_irq == 1'b0, "R9", "empty_irq in reset", empty_irq, 0);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && tx_idle == 1'b1, "R9", "after reset", {txd, tx_idle}, 3);

        // R3 R4 R8: 8-bit frames, no parity, short stop
        divisor = 16'd0;
        push(8'hA5, 1'b1);
        wait_start();
        check(tx_idle == 1'b0, "R8", "busy while sending", tx_idle, 0);
        push(8'h3C, 1'b1);
        push(8'h01, 1'b1);
        drain();

        // R4 R5 R6: every width, parity mode and stop setting
        divisor = 16'd1;
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    fmt_len       = 2'(ln);
                    fmt_par_en    = (pm != 0);
                    fmt_par_odd   = (pm == 2);
                    fmt_stop_long = sl[0];
                    run_pair(8'(8'hC7 ^ (ln * 37 + pm * 11 + sl * 90)),
                             8'(8'h5A + ln * 19 + pm * 7 + sl * 3), "R6");
                end
            end
        end

        // R2: slower tick
        divisor = 16'd5;
        fmt_len = 2'd3; fmt_par_en = 1'b1; fmt_par_odd = 1'b0; fmt_stop_long = 1'b0;
        run_pair(8'h96, 8'h0F, "R2");

        // R1: fill the queue while a frame is on the line, then overfill
        divisor = 16'd0;
        fmt_par_en = 1'b0;
        i0 = irq_cnt;
        push(8'h00, 1'b1);
        wait_start();
        for (int k = 0; k < 63; k++) push(8'(k + 1), 1'b1);
        check(fifo_full == 1'b0, "R1", "not full at 63", fifo_full, 0);
        push(8'h40, 1'b1);
        check(fifo_full == 1'b1, "R1", "full at 64", fifo_full, 1);
        push(8'hEE, 1'b0);
        check(fifo_full == 1'b1, "R1", "still full after dropped write", fifo_full, 1);
        drain();
        check(irq_cnt == i0 + 2, "R7", "empty pulses after fill", irq_cnt - i0, 2);
        check(tx_idle == 1'b1, "R8", "idle at end", tx_idle, 1);

        done = 1'b1;
        finish_run();
    end
endmodule